// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. It drives a code to an external DAC, controls an external sample/hold stage, and reads one comparator bit that is high when the DAC voltage is below the held input voltage. A conversion has two phases. The sample phase has a programmable length, and the input is tracked during it. The trial phase follows and resolves one result bit per clock, starting from the most significant bit.

The resolution and the sample length are picked with small codes each time a conversion is started. The total conversion time is therefore the sample cycles plus the result bits. A one-cycle end-of-conversion pulse marks the cycle in which a new, right-aligned result appears. A start request that arrives while a conversion is in progress is dropped.

Top module: `sar_conv_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `eoc`, `sh_track`, `dac_code` and `result` are all 0.
- R2: When `start` is high at a clock edge while idle, `busy` and `sh_track` are high from the next cycle on. `sh_track` stays high for the number of cycles set by `smp_sel`: 000→3, 001→15, 010→28, 011→56, 100→84, 101→112, 110→144, 111→480.
- R3: `res_sel` picks the result width: 00→12 bits, 01→10 bits, 10→8 bits, 11→6 bits.
- R4: Each trial cycle presents the bits already kept plus a 1 in the bit under test. Trials go from DAC bit 11 downward, one clock per bit. The tested bit is kept only if `cmp_below` is 1 in that cycle.
- R5: `busy` stays high for exactly the sample cycles plus the result bits. `eoc` is high for one cycle, the cycle right after the last trial, and `busy` is low in that cycle.
- R6: During trials at reduced resolution, the DAC code bits below the last tested bit are 0. The result is right-aligned: the kept bits shifted down by 12 minus the result width. Outside trials `dac_code` is 0.
- R7: `sh_track` is low during every trial cycle, so the input stays held while the bits are decided.
- R8: A `start` while `busy` is high is ignored. It changes neither the timing nor the resolution of the running conversion. `res_sel` and `smp_sel` are only read when a start is accepted.
- R9: `result` changes only together with `eoc` and otherwise keeps the last conversion's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, accepted only while idle |
| res_sel | input | 2 | Resolution code |
| smp_sel | input | 3 | Sample-length code |
| cmp_below | input | 1 | Comparator: 1 when the DAC voltage is below the held input |
| dac_code | output | DAC_W | Code for the external DAC |
| sh_track | output | 1 | 1 = sample/hold tracks the input, 0 = holds |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| result | output | DAC_W | Last conversion result, right-aligned |

## Verification
A wrong phase state or sample counter shows up on `sh_track` and `busy` in the first cycle it goes wrong. It also shifts the first trial code by at least one cycle. A corrupted probe or kept-bit register appears on `dac_code` within the same trial cycle. It then reaches `result` at the next `eoc`, which is at most 12 cycles later. The bench changes the live input during trials, so a missing hold changes the codes the comparator produces.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int MAX_RES = 12;
  localparam int SMP_MAX = 480;
  localparam int SMP_CW  = $clog2(SMP_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_TRIAL} sar_state_t;

  // Result width from the resolution code.
  function automatic int res_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 12;
      2'b01:   return 10;
      2'b10:   return 8;
      default: return 6;
    endcase
  endfunction

  // Sample-phase length in clocks from the sample code.
  function automatic int smp_cycles(input logic [2:0] sel);
    case (sel)
      3'd0:    return 3;
      3'd1:    return 15;
      3'd2:    return 28;
      3'd3:    return 56;
      3'd4:    return 84;
      3'd5:    return 112;
      3'd6:    return 144;
      default: return SMP_MAX;
    endcase
  endfunction
endpackage

// File: rtl/sar_smp_timer.sv
module sar_smp_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val - CNT_W'(1);
    else if (run && cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign expire = run && (cnt == '0);

  // R2
  timer_nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val != '0);
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         begin_i,
  input  logic         step_i,
  input  logic         keep_i,
  input  logic [W-1:0] stop_mask,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] acc_next_o,
  output logic         last_o
);
  logic [W-1:0] acc, probe;

  assign trial_o    = acc | probe;
  assign acc_next_o = keep_i ? (acc | probe) : acc;
  assign last_o     = |(probe & stop_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      probe <= '0;
    end else if (begin_i) begin
      acc   <= '0;
      probe <= {1'b1, {(W-1){1'b0}}};
    end else if (step_i) begin
      acc   <= acc_next_o;
      probe <= probe >> 1;
    end
  end

  // R4
  probe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe));

  // R4
  probe_walks_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !begin_i && !last_o) |=> probe == ($past(probe) >> 1));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       res_sel,
  input  logic [2:0]       smp_sel,
  input  logic             cmp_below,
  output logic [DAC_W-1:0] dac_code,
  output logic             sh_track,
  output logic             busy,
  output logic             eoc,
  output logic [DAC_W-1:0] result
);
  import sar_pkg::*;

  sar_state_t       state;
  logic [1:0]       res_q;
  logic [DAC_W-1:0] result_q;
  logic             eoc_q;

  // Named internal events.
  logic             accept, smp_done, in_trial, trial_last;
  logic [DAC_W-1:0] stop_mask, low_mask, trial_code, acc_next;
  logic [SMP_CW-1:0] smp_len;
  int               nbits, shamt;

  assign accept   = start && (state == ST_IDLE);
  assign in_trial = (state == ST_TRIAL);
  assign smp_len  = SMP_CW'(smp_cycles(smp_sel));

  always_comb begin
    nbits     = res_bits(res_q);
    shamt     = DAC_W - nbits;
    stop_mask = DAC_W'(1) << shamt;
    low_mask  = stop_mask - DAC_W'(1);
  end

  sar_smp_timer #(.CNT_W(SMP_CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (smp_len),
    .run      (state == ST_SAMPLE),
    .expire   (smp_done)
  );

  sar_bit_engine #(.W(DAC_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .begin_i    (smp_done),
    .step_i     (in_trial),
    .keep_i     (cmp_below),
    .stop_mask  (stop_mask),
    .trial_o    (trial_code),
    .acc_next_o (acc_next),
    .last_o     (trial_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      res_q    <= 2'b00;
      result_q <= '0;
      eoc_q    <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_SAMPLE;
          res_q <= res_sel;
        end
        ST_SAMPLE: if (smp_done) state <= ST_TRIAL;
        ST_TRIAL: if (trial_last) begin
          state    <= ST_IDLE;
          result_q <= acc_next >> shamt;
          eoc_q    <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dac_code = in_trial ? trial_code : '0;
  assign sh_track = (state == ST_SAMPLE);
  assign busy     = (state != ST_IDLE);
  assign eoc      = eoc_q;
  assign result   = result_q;

  // R5
  eoc_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (!busy && $past(busy)));

  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_trial |-> (dac_code & low_mask) == '0);

  // R7
  hold_in_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_track |-> dac_code == '0);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> res_q == $past(res_q));

  // R9
  result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  res_sel = 2'b00;
  logic [2:0]  smp_sel = 3'd0;
  logic        cmp_below;
  logic [11:0] dac_code, result;
  logic        sh_track, busy, eoc;

  always #2 clk = ~clk; // 250 MHz

  sar_conv_ctrl #(.DAC_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel),
    .smp_sel(smp_sel), .cmp_below(cmp_below), .dac_code(dac_code),
    .sh_track(sh_track), .busy(busy), .eoc(eoc), .result(result)
  );

  // Analog side: the input sits half an LSB above vin_live, so "DAC below input" is dac <= held.
  int vin_live = 0;
  int vin_held = 0;
  always @(posedge clk) if (sh_track) vin_held <= vin_live;
  assign cmp_below = (int'(dac_code) <= vin_held);

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R2";

  function automatic int samples_for(input int code);
    int tab[8] = '{3, 15, 28, 56, 84, 112, 144, 480};
    return tab[code];
  endfunction
  function automatic int width_for(input int code);
    return 12 - 2 * code;
  endfunction

  // Behavioural reference model, advanced at every rising edge.
  bit m_busy = 0, m_eoc = 0;
  int k = 0, s = 0, n = 0, m_held = 0, m_result = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_eoc = 0; k = 0; m_result = 0;
    end else begin
      m_eoc = 0;
      if (m_busy) begin
        if (k < s) m_held = vin_live;
        k++;
        if (k == s + n) begin
          m_busy = 0; m_eoc = 1;
          m_result = m_held >> (12 - n);
        end
      end else if (start) begin
        m_busy = 1; k = 0;
        s = samples_for(int'(smp_sel));
        n = width_for(int'(res_sel));
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_dac;
      bit e_sh;
      e_sh = m_busy && (k < s);
      e_dac = 0;
      if (m_busy && k >= s) begin
        int j;
        j = k - s;
        e_dac = ((m_held >> (12 - j)) << (12 - j)) | (1 << (11 - j));
      end
      chk({"R5 ", phase}, "busy", int'(busy), int'(m_busy));
      chk({"R2 R7 ", phase}, "sh_track", int'(sh_track), int'(e_sh));
      chk((m_busy && k >= s) ? {"R4 R6 ", phase} : {"R6 ", phase}, "dac_code",
          int'(dac_code), e_dac);
      chk({"R5 ", phase}, "eoc", int'(eoc), int'(m_eoc));
      chk({"R3 R9 ", phase}, "result", int'(result), m_result);
    end
  end

  task automatic run_conv(input int rs, input int sm, input int vin);
    @(negedge clk);
    res_sel = 2'(rs); smp_sel = 3'(sm); vin_live = vin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (samples_for(sm)) @(negedge clk);
    vin_live = 4095 - vin; // live input moves; the held value must not (R7)
    repeat (width_for(rs) + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "eoc", int'(eoc), 0);
    chk("R1", "sh_track", int'(sh_track), 0);
    chk("R1", "dac_code", int'(dac_code), 0);
    chk("R1", "result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", int'(busy), 0);

    phase = "R3";
    run_conv(0, 0, 12'hA5C);
    run_conv(0, 0, 0);
    run_conv(0, 0, 4095);
    run_conv(1, 1, 1234);
    run_conv(2, 2, 777);
    run_conv(3, 3, 4000);
    phase = "R2";
    for (int c = 0; c < 8; c++) run_conv(c % 4, c, 311 * (c + 3));

    // R8: start pulses while busy must be ignored
    phase = "R8";
    @(negedge clk);
    res_sel = 2'b11; smp_sel = 3'd1; vin_live = 3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    res_sel = 2'b00; smp_sel = 3'd7; start = 1'b1; // during sample
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
    start = 1'b1; // during trials
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8", "busy after ignored starts", int'(busy), 0);
    chk("R8", "result width kept at 6 bits", int'(result), 3000 >> 6);

    // Back-to-back: start held high, restarts in the eoc cycle
    phase = "R5";
    res_sel = 2'b10; smp_sel = 3'd0; vin_live = 2049; start = 1'b1;
    repeat (30) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule